// File: doc/BRIEF.md
# Key-Unlocked Indexed Configuration Port

This block is a byte-wide configuration front end that a host reaches through two adjacent I/O addresses. One address is the index port and the other is the data port. The host writes a register number to the index port. The next data-port access then reads or writes that register.

The whole configuration space stays hidden until the host writes a key byte twice in a row to the index port. A different key byte written to the index port closes it again. While it is open, the block answers identification reads itself and keeps a logical-device select register. Every index from 0x30 upward goes to the selected attached function through a side port: a register number, write data, and per-device read and write strobes. Read data comes back combinationally from that device.

Host read data is combinational and follows `bus_sel`. It is meaningful while `bus_rd` is high. Side-port strobes are asserted in the same cycle as the host access.

Top module: `cfg_index_port`

## Requirements
- R1: After reset the port is locked, and once it is unlocked both the index register and the device select read 0x00.
- R2: Two consecutive index-port writes of 0x87 open the port. While the port is open, index-port writes other than 0xAA store the index, and index-port reads return it.
- R3: In the half-open state (one 0x87 seen), an index-port write of any other value returns the port to locked. The sequence 0x87, other, 0x87 therefore leaves the port half-open, not open.
- R4: An index-port write of 0xAA while open locks the port, and 0xAA is not stored as the index. After the next unlock, the index holds its old value.
- R5: While the port is not open, every read of either port returns 0xFF, data-port writes change nothing, no side-port strobe fires, and index writes other than the key are not stored.
- R6: Index 0x07 is the device select: data-port writes store the byte, and data-port reads return it.
- R7: Indices 0x20/0x21 return DEV_ID high/low byte, 0x22 returns REV, and 0x23/0x24 return MFG_ID high/low byte. Data writes to these indices are dropped.
- R8: With the index at 0x30 or above and the select value s below NUM_LD, a data write pulses only dev_wr[s] and a data read pulses only dev_rd[s]. During the access dev_reg equals the index and dev_wdata equals the host byte, and the read returns device s's byte.
- R9: Indices 0x00–0x2F other than 0x07 and 0x20–0x24 read 0x00, accept no writes, and raise no strobe.
- R10: With the select value at NUM_LD or above, window accesses raise no strobe and reads return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | 0 = index port, 1 = data port |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Host read byte for the port selected by bus_sel |
| dev_reg | output | 8 | Register index presented to the devices |
| dev_wdata | output | 8 | Write byte presented to the devices |
| dev_wr | output | NUM_LD | Per-device write strobe |
| dev_rd | output | NUM_LD | Per-device read strobe |
| dev_rdata | input | 8*NUM_LD | Read bytes from the devices, device i at bits 8i+7:8i |

## Verification
On every cycle, the assertions check the following:
- The port only opens right after a second key write.
- A broken key sequence falls back to locked.
- The close key always locks the port.
- No strobe escapes while the port is locked.
- The strobe vectors stay one-hot or zero.
- The device select changes only on a data write at index 0x07.

Some behaviour can only be shown by the bench's scenarios with the cycle-by-cycle reference model:
- the read-back values of every index class;
- index retention across a lock and unlock;
- the 0x87, other, 0x87 corner;
- the behaviour with an out-of-range select.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

    typedef enum logic [1:0] {
        ST_LOCKED = 2'd0,
        ST_ARMED  = 2'd1,
        ST_OPEN   = 2'd2
    } lock_state_t;

    localparam logic [7:0] KEY_OPEN    = 8'h87;
    localparam logic [7:0] KEY_CLOSE   = 8'hAA;
    localparam logic [7:0] IX_DEVSEL   = 8'h07;
    localparam logic [7:0] IX_ID_HI    = 8'h20;
    localparam logic [7:0] IX_ID_LO    = 8'h21;
    localparam logic [7:0] IX_REV      = 8'h22;
    localparam logic [7:0] IX_MFG_HI   = 8'h23;
    localparam logic [7:0] IX_MFG_LO   = 8'h24;
    localparam logic [7:0] IX_WIN_BASE = 8'h30;
    localparam logic [7:0] IDLE_BYTE   = 8'hFF;

    function automatic logic in_window(input logic [7:0] ix);
        return ix >= IX_WIN_BASE;
    endfunction

endpackage

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
    import cfg_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       unlocked
);

    lock_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (idx_wr) begin
            unique case (state_q)
                ST_LOCKED: state_d = (wdata == KEY_OPEN)  ? ST_ARMED  : ST_LOCKED;
                ST_ARMED:  state_d = (wdata == KEY_OPEN)  ? ST_OPEN   : ST_LOCKED;
                ST_OPEN:   state_d = (wdata == KEY_CLOSE) ? ST_LOCKED : ST_OPEN;
                default:   state_d = ST_LOCKED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_LOCKED;
        else     state_q <= state_d;
    end

    assign unlocked = (state_q == ST_OPEN);

    // R2
    unlock_key_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_OPEN && $past(state_q) != ST_OPEN) |->
        ($past(idx_wr) && $past(wdata) == KEY_OPEN && $past(state_q) == ST_ARMED));

    // R3
    broken_key_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ARMED && idx_wr && wdata != KEY_OPEN) |=> (state_q == ST_LOCKED));

    // R4
    relock_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_OPEN && idx_wr && wdata == KEY_CLOSE) |=> (state_q == ST_LOCKED));

endmodule

// File: rtl/cfg_reg_core.sv
module cfg_reg_core
    import cfg_port_pkg::*;
#(
    parameter logic [15:0] DEV_ID = 16'h0541,
    parameter logic [7:0]  REV    = 8'h01,
    parameter logic [15:0] MFG_ID = 16'h1934
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       unlocked,
    input  logic       idx_wr,
    input  logic       dat_wr,
    input  logic [7:0] wdata,
    output logic [7:0] index,
    output logic [7:0] ld_sel,
    output logic [7:0] local_rdata,
    output logic       win_hit
);

    logic [7:0] index_q, ld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            index_q <= 8'h00;
            ld_q    <= 8'h00;
        end else if (unlocked) begin
            if (idx_wr && wdata != KEY_CLOSE)
                index_q <= wdata;
            if (dat_wr && index_q == IX_DEVSEL)
                ld_q <= wdata;
        end
    end

    always_comb begin
        unique case (index_q)
            IX_DEVSEL: local_rdata = ld_q;
            IX_ID_HI:  local_rdata = DEV_ID[15:8];
            IX_ID_LO:  local_rdata = DEV_ID[7:0];
            IX_REV:    local_rdata = REV;
            IX_MFG_HI: local_rdata = MFG_ID[15:8];
            IX_MFG_LO: local_rdata = MFG_ID[7:0];
            default:   local_rdata = 8'h00;
        endcase
    end

    assign index   = index_q;
    assign ld_sel  = ld_q;
    assign win_hit = unlocked && in_window(index_q);

    // R6
    ldsel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(unlocked && dat_wr && index_q == IX_DEVSEL) |=> $stable(ld_q));

endmodule

// File: rtl/cfg_ld_fanout.sv
module cfg_ld_fanout #(
    parameter int NUM_LD = 8
) (
    input  logic                win_hit,
    input  logic [7:0]          ld_sel,
    input  logic                dat_wr,
    input  logic                dat_rd,
    input  logic [NUM_LD*8-1:0] dev_rdata,
    output logic [NUM_LD-1:0]   dev_wr,
    output logic [NUM_LD-1:0]   dev_rd,
    output logic [7:0]          win_rdata
);

    logic [NUM_LD-1:0] hit_vec;

    for (genvar g = 0; g < NUM_LD; g++) begin : g_ld
        assign hit_vec[g] = win_hit && (ld_sel == 8'(g));
        assign dev_wr[g]  = hit_vec[g] && dat_wr;
        assign dev_rd[g]  = hit_vec[g] && dat_rd;
    end

    always_comb begin
        win_rdata = 8'hFF;
        for (int i = 0; i < NUM_LD; i++)
            if (hit_vec[i]) win_rdata = dev_rdata[i*8 +: 8];
    end

endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
    import cfg_port_pkg::*;
#(
    parameter int          NUM_LD = 8,
    parameter logic [15:0] DEV_ID = 16'h0541,
    parameter logic [7:0]  REV    = 8'h01,
    parameter logic [15:0] MFG_ID = 16'h1934
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [7:0]          bus_wdata,
    output logic [7:0]          bus_rdata,
    output logic [7:0]          dev_reg,
    output logic [7:0]          dev_wdata,
    output logic [NUM_LD-1:0]   dev_wr,
    output logic [NUM_LD-1:0]   dev_rd,
    input  logic [NUM_LD*8-1:0] dev_rdata
);

    logic       idx_wr, dat_wr, dat_rd, unlocked, win_hit;
    logic [7:0] index, ld_sel, local_rdata, win_rdata;

    assign idx_wr = bus_wr && !bus_sel;
    assign dat_wr = bus_wr &&  bus_sel;
    assign dat_rd = bus_rd &&  bus_sel;

    cfg_key_fsm u_fsm (
        .clk(clk), .rst(rst), .idx_wr(idx_wr), .wdata(bus_wdata), .unlocked(unlocked)
    );

    cfg_reg_core #(.DEV_ID(DEV_ID), .REV(REV), .MFG_ID(MFG_ID)) u_regs (
        .clk(clk), .rst(rst), .unlocked(unlocked), .idx_wr(idx_wr), .dat_wr(dat_wr),
        .wdata(bus_wdata), .index(index), .ld_sel(ld_sel),
        .local_rdata(local_rdata), .win_hit(win_hit)
    );

    cfg_ld_fanout #(.NUM_LD(NUM_LD)) u_fan (
        .win_hit(win_hit), .ld_sel(ld_sel), .dat_wr(dat_wr), .dat_rd(dat_rd),
        .dev_rdata(dev_rdata), .dev_wr(dev_wr), .dev_rd(dev_rd), .win_rdata(win_rdata)
    );

    always_comb begin
        if (!unlocked)    bus_rdata = IDLE_BYTE;
        else if (!bus_sel) bus_rdata = index;
        else if (win_hit) bus_rdata = win_rdata;
        else              bus_rdata = local_rdata;
    end

    assign dev_reg   = index;
    assign dev_wdata = bus_wdata;

    // R5
    locked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !unlocked |-> (dev_wr == '0 && dev_rd == '0));

    // R8
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dev_wr) && $onehot0(dev_rd));

endmodule

// File: tb/tb_cfg_index_port.sv
`timescale 1ns/1ps
module tb_cfg_index_port;

    localparam int          N   = 8;
    localparam logic [15:0] DID = 16'h0909;
    localparam logic [7:0]  RV  = 8'h5C;
    localparam logic [15:0] MID = 16'h1934;

    logic clk = 0, rst = 1;
    logic bus_sel = 0, bus_wr = 0, bus_rd = 0;
    logic [7:0] bus_wdata = 0, bus_rdata, dev_reg, dev_wdata;
    logic [N-1:0] dev_wr, dev_rd;
    logic [N*8-1:0] dev_rdata;

    int tests = 0, fails = 0;
    int m_state = 0;        // 0 locked, 1 half-open, 2 open
    int m_idx = 0, m_ld = 0;

    always #2 clk = ~clk;

    always_comb
        for (int i = 0; i < N; i++) dev_rdata[i*8 +: 8] = (8'hA0 + 8'(i)) ^ dev_reg;

    cfg_index_port #(.NUM_LD(N), .DEV_ID(DID), .REV(RV), .MFG_ID(MID)) dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_reg(dev_reg),
        .dev_wdata(dev_wdata), .dev_wr(dev_wr), .dev_rd(dev_rd), .dev_rdata(dev_rdata)
    );

    function automatic logic [7:0] exp_read(input logic sel);
        if (m_state != 2) return 8'hFF;
        if (!sel) return 8'(m_idx);
        if (m_idx >= 8'h30) return (m_ld < N) ? ((8'hA0 + 8'(m_ld)) ^ 8'(m_idx)) : 8'hFF;
        case (m_idx)
            8'h07: return 8'(m_ld);
            8'h20: return DID[15:8];
            8'h21: return DID[7:0];
            8'h22: return RV;
            8'h23: return MID[15:8];
            8'h24: return MID[7:0];
            default: return 8'h00;
        endcase
    endfunction

    task automatic cyc(input logic sel, input logic wr, input logic rd,
                       input logic [7:0] d, input string tag);
        logic [N-1:0] ew, er;
        logic [7:0] erd;
        logic bad;
        @(negedge clk);
        bus_sel = sel; bus_wr = wr; bus_rd = rd; bus_wdata = d;
        #1;
        ew = '0; er = '0;
        if (m_state == 2 && m_idx >= 8'h30 && m_ld < N && sel) begin
            if (wr) ew[m_ld] = 1'b1;
            if (rd) er[m_ld] = 1'b1;
        end
        erd = exp_read(sel);
        bad = (dev_wr !== ew) || (dev_rd !== er) || (rd && bus_rdata !== erd) ||
              ((ew != 0 || er != 0) && (dev_reg !== 8'(m_idx) || dev_wdata !== d));
        tests++;
        if (bad) begin
            fails++;
            $display("FAIL %s: rdata=%02h/%02h wr=%b/%b rd=%b/%b reg=%02h/%02h (actual/expected)",
                     tag, bus_rdata, erd, dev_wr, ew, dev_rd, er, dev_reg, 8'(m_idx));
        end
        // model update for the coming edge
        if (wr && !sel) begin
            case (m_state)
                0: m_state = (d == 8'h87) ? 1 : 0;
                1: m_state = (d == 8'h87) ? 2 : 0;
                default: if (d == 8'hAA) m_state = 0; else m_idx = d;
            endcase
        end else if (wr && sel && m_state == 2 && m_idx == 8'h07) begin
            m_ld = d;
        end
    endtask

    task automatic iw(input logic [7:0] d, input string t); cyc(0, 1, 0, d, t); endtask
    task automatic dw(input logic [7:0] d, input string t); cyc(1, 1, 0, d, t); endtask
    task automatic dr(input string t); cyc(1, 0, 1, 8'h00, t); endtask
    task automatic ir(input string t); cyc(0, 0, 1, 8'h00, t); endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        repeat (3) @(negedge clk);
        rst = 0;
        // R5: locked behaviour
        dr("R5"); ir("R5"); iw(8'h07, "R5"); dw(8'h09, "R5");
        iw(8'h40, "R5"); dw(8'h11, "R5"); dr("R5");
        // R3: broken sequences
        iw(8'h87, "R3"); iw(8'h12, "R3"); dr("R3");
        iw(8'h87, "R3"); iw(8'h55, "R3"); iw(8'h87, "R3"); dr("R3"); ir("R3");
        // R2: second key opens
        iw(8'h87, "R2");
        // R1: reset values visible after unlock
        ir("R1"); iw(8'h07, "R1"); dr("R1");
        // R9: reserved indices
        iw(8'h00, "R9"); dr("R9"); dw(8'h3C, "R9"); dr("R9");
        iw(8'h2F, "R9"); dw(8'h11, "R9"); dr("R9");
        // R7: identification
        iw(8'h20, "R7"); dr("R7"); dw(8'h77, "R7"); dr("R7");
        iw(8'h21, "R7"); dr("R7"); iw(8'h22, "R7"); dr("R7"); dw(8'h00, "R7"); dr("R7");
        iw(8'h23, "R7"); dr("R7"); iw(8'h24, "R7"); dr("R7");
        // R6 / R8: select and window
        for (int s = 0; s < N; s += 3) begin
            iw(8'h07, "R6"); dw(8'(s), "R6"); dr("R6");
            iw(8'h30, "R8"); dw(8'h5A, "R8"); dr("R8");
            iw(8'hFF, "R8"); dr("R8"); dw(8'hC3, "R8");
            ir("R2");
        end
        // R10: out-of-range select
        iw(8'h07, "R10"); dw(8'(N), "R10"); iw(8'h44, "R10"); dr("R10"); dw(8'h01, "R10");
        iw(8'h07, "R10"); dw(8'h02, "R10");
        // R4: close key, index retention
        iw(8'h51, "R4"); iw(8'hAA, "R4"); dr("R4"); ir("R4"); dw(8'h00, "R4");
        iw(8'h87, "R4"); iw(8'h87, "R4"); ir("R4"); dr("R4");
        // mixed traffic against the model
        lf = 16'hACE1;
        for (int k = 0; k < 400; k++) begin
            logic [7:0] d;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            case (lf[5:3])
                3'd0, 3'd1: d = 8'h87;
                3'd2: d = 8'hAA;
                3'd3: d = 8'h07;
                default: d = lf[15:8];
            endcase
            cyc(lf[0], lf[1], lf[2] & ~lf[1], (lf[0] && lf[5:3] == 3'd3) ? 8'(lf[9:8]) : d, "R8");
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule